// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block consumes one circular ring of 16-byte transmit descriptors kept in a word-addressed descriptor memory with 32-bit words. Software fills descriptors and moves a head index forward. The walker keeps its own tail index and works from the tail toward the head, one descriptor at a time. For each descriptor it fetches the 64-bit buffer address and the control word, then presents a transfer request that carries the address, the byte length and the start and end frame codes. When the data mover answers with done, the walker sets the completed flag in the descriptor's control word in memory and moves the tail on. The tail returns to zero after the last slot of the ring.

A descriptor occupies four consecutive words starting at `ring_base + 4*index`. Word 0 holds address bits 31:0 and word 1 holds address bits 63:32. Word 2 is the control word: length in bits 11:0, end-of-frame code in bits 15:12, start-of-frame code in bits 19:16, and flags in bits 31:20. The flags are isochronous at bit 20, completed at bit 21, posted at bit 22 and interrupt request at bit 23. Word 3 is a time word that software leaves at zero, and the walker never reads it. A one-cycle notify pulse reports each completed descriptor that asked for an interrupt. A descriptor whose posted flag is clear stops the walker and sets a sticky error flag.

The run input is the enable bit (bit 31) of the ring's options word. The register block around the walker supplies it. The other option bits belong to the data path and have no effect on the walker.

Top module: `txring_walker`

## Requirements
- R1: After reset, `hw_tail` is 0, `xfer_req`, `notify`, `ring_err`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: When `opt_run` is 0, or when `hw_tail` equals `sw_head`, the walker issues no memory read.
- R3: A descriptor is fetched with three reads in consecutive cycles, at word addresses `ring_base + 4*tail + 0`, `+1` and `+2`. Read data returns one cycle after `mem_rd_en`. Reads and writes never occur in the same cycle.
- R4: `xfer_req` rises after the fetch and carries `xfer_addr` = {word1, word0}, `xfer_len` = word2[11:0], `xfer_eof` = word2[15:12] and `xfer_sof` = word2[19:16]. It stays high with these fields stable until the cycle in which `xfer_done` is high.
- R5: In the cycle after the done handshake, the walker writes word 2 back to `ring_base + 4*tail + 2` with bit 21 (completed) set and all other bits unchanged. `hw_tail` takes its new value at the clock edge that ends this write cycle.
- R6: The tail advances from `ring_count - 1` to 0, and otherwise by one.
- R7: `notify` pulses for exactly the write-back cycle of a descriptor with bit 23 (interrupt request) set, and never for any other descriptor.
- R8: If word 2 has bit 22 (posted) clear, `ring_err` rises and stays high until reset. No transfer is requested, the tail does not move, and no further memory access takes place.
- R9: Dropping `opt_run` while a descriptor is in flight lets that descriptor complete and advance the tail. No later descriptor is fetched until `opt_run` returns.
- R10: With several descriptors pending, the walker processes them in ring order until the tail equals the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opt_run | input | 1 | Ring enable, bit 31 of the options word |
| ring_base | input | AW | Word address of descriptor 0 |
| ring_count | input | IW | Number of descriptors in the ring (at least 1) |
| sw_head | input | IW | Index of the first descriptor software has not posted |
| hw_tail | output | IW | Index of the next descriptor the walker will consume |
| mem_rd_en | output | 1 | Descriptor memory read strobe |
| mem_wr_en | output | 1 | Descriptor memory write strobe |
| mem_addr | output | AW | Descriptor memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after the read strobe |
| xfer_req | output | 1 | Transfer request, held until done |
| xfer_addr | output | 64 | Buffer address of the transfer |
| xfer_len | output | 12 | Transfer length in bytes |
| xfer_sof | output | 4 | Start-of-frame code |
| xfer_eof | output | 4 | End-of-frame code |
| xfer_done | input | 1 | Transfer finished; sampled while `xfer_req` is high |
| notify | output | 1 | One-cycle completion pulse for descriptors that request it |
| ring_err | output | 1 | Sticky flag: an unposted descriptor was reached |

## Verification
The hardest case to reach from the ports is a run-enable drop that lands while a transfer is outstanding. The stimulus stretches the done response to many cycles, watches for `xfer_req` to rise, and only then clears `opt_run`. This proves that the in-flight descriptor finishes while the next pending one stays untouched. A second hard case is the write-back cycle itself, where the tail must still show its old value while the completed word is written. The bench samples the cycle after done and the cycle after that, and does so on a descriptor sitting in the last ring slot, so the same sequence also covers the wrap to zero.

// File: rtl/txring_pkg.sv
package txring_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FA0,
      ST_FA1,
      ST_FA2,
      ST_XFER,
      ST_WB,
      ST_HALT
   } walk_st_e;

   // control word layout (word 2 of a descriptor)
   localparam int LEN_W     = 12;
   localparam int CODE_W    = 4;
   localparam int FLG_LSB   = 20;
   localparam int FLG_ISOCH = 0;
   localparam int FLG_DONE  = 1;
   localparam int FLG_POST  = 2;
   localparam int FLG_IRQ   = 3;
   localparam int WORDS_PER_DESC = 4;
   localparam int CTL_WORD  = 2;

   typedef struct packed {
      logic [11:0] flags;
      logic [3:0]  sof;
      logic [3:0]  eof;
      logic [11:0] len;
   } ctl_word_t;

endpackage

// File: rtl/txring_ctl_decode.sv
module txring_ctl_decode
   import txring_pkg::*;
(
   input  logic [31:0]        ctl_in,
   output logic [LEN_W-1:0]   len,
   output logic [CODE_W-1:0]  sof,
   output logic [CODE_W-1:0]  eof,
   output logic               irq_req,
   output logic [31:0]        ctl_done
);
   ctl_word_t c;
   ctl_word_t c_done;

   always_comb begin
      c              = ctl_word_t'(ctl_in);
      len            = c.len;
      sof            = c.sof;
      eof            = c.eof;
      irq_req        = c.flags[FLG_IRQ];
      c_done         = c;
      c_done.flags[FLG_DONE] = 1'b1;
      ctl_done       = 32'(c_done);
   end
endmodule

// File: rtl/txring_addr_gen.sv
module txring_addr_gen #(
   parameter int AW = 16,
   parameter int IW = 11
) (
   input  logic [AW-1:0] base,
   input  logic [IW-1:0] index,
   input  logic [1:0]    word_sel,
   output logic [AW-1:0] addr
);
   localparam int SLOT_W = IW + 2;

   logic [SLOT_W-1:0] slot_off;

   always_comb begin
      slot_off = {index, word_sel};
      addr     = base + AW'(slot_off);
   end
endmodule

// File: rtl/txring_tail_ctr.sv
module txring_tail_ctr #(
   parameter int IW        = 11,
   parameter bit POW2_WRAP = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic [IW-1:0] count,
   output logic [IW-1:0] tail
);
   logic [IW-1:0] tail_nxt;

   generate
      if (POW2_WRAP) begin : g_pow2
         logic [IW-1:0] count_unused;
         assign count_unused = count;
         assign tail_nxt     = tail + IW'(1);
      end else begin : g_count
         assign tail_nxt = (tail == count - IW'(1)) ? '0 : tail + IW'(1);

         assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (inc && (tail == count - IW'(1))) |=> (tail == '0));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   tail <= '0;
      else if (inc) tail <= tail_nxt;
   end

   assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(tail));
endmodule

// File: rtl/txring_walker.sv
module txring_walker
   import txring_pkg::*;
#(
   parameter int AW        = 16,
   parameter int IW        = 11,
   parameter bit POW2_WRAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              opt_run,
   input  logic [AW-1:0]     ring_base,
   input  logic [IW-1:0]     ring_count,
   input  logic [IW-1:0]     sw_head,
   output logic [IW-1:0]     hw_tail,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [AW-1:0]     mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              xfer_req,
   output logic [63:0]       xfer_addr,
   output logic [LEN_W-1:0]  xfer_len,
   output logic [CODE_W-1:0] xfer_sof,
   output logic [CODE_W-1:0] xfer_eof,
   input  logic              xfer_done,
   output logic              notify,
   output logic              ring_err
);
   localparam int POST_BIT = FLG_LSB + FLG_POST;

   generate
      if (AW < IW + 2) begin : g_bad_aw
         $error("txring_walker: AW must cover IW plus two word-select bits");
      end
      if (IW < 1 || IW > 16) begin : g_bad_iw
         $error("txring_walker: IW out of supported range");
      end
   endgenerate

   walk_st_e    st_q, st_d;
   logic [31:0] addr_lo_q, addr_hi_q, ctl_q;
   logic        err_q;
   logic        start;
   logic        irq_req;
   logic        tail_inc;
   logic [1:0]  word_sel;
   logic [31:0] ctl_done;

   assign start    = (st_q == ST_IDLE) && opt_run && !err_q && (hw_tail != sw_head);
   assign tail_inc = (st_q == ST_WB);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (start) st_d = ST_FA0;
         ST_FA0:  st_d = ST_FA1;
         ST_FA1:  st_d = ST_FA2;
         ST_FA2:  st_d = mem_rdata[POST_BIT] ? ST_XFER : ST_HALT;
         ST_XFER: if (xfer_done) st_d = ST_WB;
         ST_WB:   st_d = ST_IDLE;
         ST_HALT: st_d = ST_HALT;
         default: st_d = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (st_q)
         ST_FA0:  word_sel = 2'd1;
         ST_FA1:  word_sel = 2'(CTL_WORD);
         ST_WB:   word_sel = 2'(CTL_WORD);
         default: word_sel = 2'd0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_lo_q <= '0;
         addr_hi_q <= '0;
         ctl_q     <= '0;
         err_q     <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_FA0) addr_lo_q <= mem_rdata;
         if (st_q == ST_FA1) addr_hi_q <= mem_rdata;
         if (st_q == ST_FA2) begin
            ctl_q <= mem_rdata;
            if (!mem_rdata[POST_BIT]) err_q <= 1'b1;
         end
      end
   end

   txring_tail_ctr #(.IW(IW), .POW2_WRAP(POW2_WRAP)) i_tail (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (tail_inc),
      .count (ring_count),
      .tail  (hw_tail)
   );

   txring_addr_gen #(.AW(AW), .IW(IW)) i_addr (
      .base     (ring_base),
      .index    (hw_tail),
      .word_sel (word_sel),
      .addr     (mem_addr)
   );

   txring_ctl_decode i_dec (
      .ctl_in   (ctl_q),
      .len      (xfer_len),
      .sof      (xfer_sof),
      .eof      (xfer_eof),
      .irq_req  (irq_req),
      .ctl_done (ctl_done)
   );

   assign mem_rd_en = start || (st_q == ST_FA0) || (st_q == ST_FA1);
   assign mem_wr_en = (st_q == ST_WB);
   assign mem_wdata = ctl_done;
   assign xfer_req  = (st_q == ST_XFER);
   assign xfer_addr = {addr_hi_q, addr_lo_q};
   assign notify    = (st_q == ST_WB) && irq_req;
   assign ring_err  = err_q;

   // checks
   assert_no_rdwr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len)));

   assert_wb_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> $past(xfer_req && xfer_done));

   assert_tail_on_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_tail != $past(hw_tail)) |-> $past(mem_wr_en));

   assert_notify_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      notify |-> mem_wr_en);

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ring_err |=> (ring_err && !mem_rd_en && !xfer_req));
endmodule

// File: tb/test_txring_walker.sv
`timescale 1ns/1ps
module test_txring_walker;
   localparam int AW = 16;
   localparam int IW = 11;
   localparam logic [31:0] DONE_BIT = 32'h0020_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic opt_run = 1'b0;
   logic [AW-1:0] ring_base = 16'd16;
   logic [IW-1:0] ring_count = 11'd4;
   logic [IW-1:0] sw_head = '0;
   logic [IW-1:0] hw_tail;
   logic mem_rd_en, mem_wr_en;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic xfer_req;
   logic [63:0] xfer_addr;
   logic [11:0] xfer_len;
   logic [3:0] xfer_sof, xfer_eof;
   logic xfer_done;
   logic notify, ring_err;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   int done_delay = 0;
   int resp_cnt = 0;

   logic [31:0] mem [0:255];
   int n_rd = 0, n_xf = 0, n_ntf = 0;
   logic [AW-1:0] rd_log [0:127];
   logic [63:0] xf_addr_log [0:31];
   logic [31:0] xf_ctl_log [0:31];

   always #10 clk = ~clk;

   txring_walker #(.AW(AW), .IW(IW)) i_txring_walker (
      .clk(clk), .rst_n(rst_n), .opt_run(opt_run), .ring_base(ring_base),
      .ring_count(ring_count), .sw_head(sw_head), .hw_tail(hw_tail),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .xfer_req(xfer_req),
      .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_sof(xfer_sof),
      .xfer_eof(xfer_eof), .xfer_done(xfer_done), .notify(notify),
      .ring_err(ring_err)
   );

   // memory, data-mover responder and monitors
   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (mem_rd_en) begin
         mem_rdata <= mem[mem_addr[7:0]];
         rd_log[n_rd[6:0]] <= mem_addr;
         n_rd <= n_rd + 1;
      end
      if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wdata;
      if (notify) n_ntf <= n_ntf + 1;
      if (xfer_req && xfer_done) begin
         xf_addr_log[n_xf[4:0]] <= xfer_addr;
         xf_ctl_log[n_xf[4:0]]  <= {8'h00, xfer_sof, xfer_eof, xfer_len};
         n_xf <= n_xf + 1;
      end
      if (!rst_n) begin
         xfer_done <= 1'b0;
         resp_cnt  <= 0;
      end else if (xfer_req && !xfer_done) begin
         if (resp_cnt >= done_delay) begin
            xfer_done <= 1'b1;
            resp_cnt  <= 0;
         end else resp_cnt <= resp_cnt + 1;
      end else xfer_done <= 1'b0;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] ctlw(input logic [11:0] len, input logic [3:0] eof,
                                        input logic [3:0] sof, input logic [11:0] flg);
      return {flg, sof, eof, len};
   endfunction

   task automatic put_desc(input int idx, input logic [63:0] a, input logic [31:0] c);
      int w;
      w = 16 + 4 * idx;
      mem[w]   = a[31:0];
      mem[w+1] = a[63:32];
      mem[w+2] = c;
      mem[w+3] = 32'h0;
   endtask

   task automatic wait_tail(input logic [IW-1:0] t, input int limit, input string req);
      int k;
      k = 0;
      while (hw_tail != t && k < limit) begin
         @(negedge clk);
         k++;
      end
      chk(hw_tail == t, req, "tail reach", 64'(hw_tail), 64'(t));
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(hw_tail == 0, "R1", "tail", 64'(hw_tail), 0);
      chk(!xfer_req && !notify && !ring_err, "R1", "req/notify/err",
          {61'd0, xfer_req, notify, ring_err}, 0);
      chk(!mem_rd_en && !mem_wr_en, "R1", "mem strobes", {62'd0, mem_rd_en, mem_wr_en}, 0);
   endtask

   task automatic t_idle;
      int r0;
      r0 = n_rd;
      put_desc(0, 64'h1, ctlw(12'd1, 4'd0, 4'd0, 12'h004));
      sw_head = 11'd2;
      opt_run = 1'b0;
      repeat (20) @(negedge clk);
      chk(n_rd == r0, "R2", "reads while disabled", 64'(n_rd - r0), 0);
      sw_head = 11'd0;
      opt_run = 1'b1;
      repeat (20) @(negedge clk);
      chk(n_rd == r0, "R2", "reads on empty ring", 64'(n_rd - r0), 0);
   endtask

   task automatic t_basic;
      int r0, x0, n0;
      logic [31:0] c0, c1, c2;
      r0 = n_rd; x0 = n_xf; n0 = n_ntf;
      c0 = ctlw(12'h040, 4'h3, 4'h5, 12'h004);
      c1 = ctlw(12'hFFF, 4'hA, 4'hC, 12'h00C);
      c2 = ctlw(12'h001, 4'h0, 4'hF, 12'h005);
      put_desc(0, 64'h1111_2222_0000_0100, c0);
      put_desc(1, 64'hAAAA_0000_0000_2000, c1);
      put_desc(2, 64'h0000_0000_DEAD_BEE0, c2);
      done_delay = 0;
      sw_head = 11'd3;
      wait_tail(11'd3, 200, "R10");
      repeat (3) @(negedge clk);
      chk(n_rd - r0 == 9, "R3", "read count", 64'(n_rd - r0), 9);
      chk(rd_log[r0] == 16 && rd_log[r0+1] == 17 && rd_log[r0+2] == 18, "R3",
          "first read addresses", 64'(rd_log[r0+2]), 18);
      chk(rd_log[r0+3] == 20 && rd_log[r0+8] == 26, "R3", "later read addresses",
          64'(rd_log[r0+8]), 26);
      chk(n_xf - x0 == 3, "R10", "transfer count", 64'(n_xf - x0), 3);
      chk(xf_addr_log[x0] == 64'h1111_2222_0000_0100, "R4", "addr d0", xf_addr_log[x0],
          64'h1111_2222_0000_0100);
      chk(xf_ctl_log[x0+1] == {8'h00, 4'hC, 4'hA, 12'hFFF}, "R4", "len/codes d1",
          64'(xf_ctl_log[x0+1]), 64'({8'h00, 4'hC, 4'hA, 12'hFFF}));
      chk(xf_addr_log[x0+2] == 64'h0000_0000_DEAD_BEE0 &&
          xf_ctl_log[x0+2] == {8'h00, 4'hF, 4'h0, 12'h001}, "R10", "order d2",
          xf_addr_log[x0+2], 64'hDEAD_BEE0);
      chk(mem[18] == (c0 | DONE_BIT) && mem[22] == (c1 | DONE_BIT), "R5",
          "completed written back", 64'(mem[22]), 64'(c1 | DONE_BIT));
      chk(mem[26] == (c2 | DONE_BIT) && mem[19] == 0, "R5", "d2 write-back",
          64'(mem[26]), 64'(c2 | DONE_BIT));
      chk(n_ntf - n0 == 1, "R7", "notify count", 64'(n_ntf - n0), 1);
   endtask

   task automatic t_wrap;
      logic [63:0] a_cap;
      logic [31:0] c3;
      bit stable_ok;
      int k, x0;
      x0 = n_xf;
      c3 = ctlw(12'h123, 4'h6, 4'h7, 12'h00C);
      put_desc(3, 64'h5555_6666_7777_8888, c3);
      put_desc(0, 64'h0000_0001_0000_0040, ctlw(12'h010, 4'h1, 4'h2, 12'h004));
      done_delay = 4;
      sw_head = 11'd1;
      k = 0;
      while (!xfer_req && k < 50) begin @(negedge clk); k++; end
      a_cap = xfer_addr;
      stable_ok = 1'b1;
      k = 0;
      while (!xfer_done && k < 50) begin
         if (!xfer_req || xfer_addr != a_cap) stable_ok = 1'b0;
         @(negedge clk);
         k++;
      end
      chk(stable_ok && a_cap == 64'h5555_6666_7777_8888, "R4", "request held",
          a_cap, 64'h5555_6666_7777_8888);
      @(negedge clk);
      chk(mem_wr_en && mem_addr == 30 && mem_wdata == (c3 | DONE_BIT), "R5",
          "write-back cycle", 64'(mem_wdata), 64'(c3 | DONE_BIT));
      chk(hw_tail == 3, "R5", "tail during write-back", 64'(hw_tail), 3);
      chk(notify, "R7", "notify in write-back", 64'(notify), 1);
      @(negedge clk);
      chk(hw_tail == 0, "R6", "wrap to zero", 64'(hw_tail), 0);
      chk(!notify, "R7", "notify one cycle", 64'(notify), 0);
      wait_tail(11'd1, 200, "R6");
      repeat (3) @(negedge clk);
      chk(n_xf - x0 == 2 && xf_addr_log[x0+1] == 64'h0000_0001_0000_0040, "R6",
          "slot 0 after wrap", xf_addr_log[x0+1], 64'h0000_0001_0000_0040);
   endtask

   task automatic t_run_drop;
      int k, x0;
      x0 = n_xf;
      put_desc(1, 64'hA1, ctlw(12'd5, 4'd0, 4'd0, 12'h004));
      put_desc(2, 64'hA2, ctlw(12'd6, 4'd0, 4'd0, 12'h004));
      done_delay = 10;
      sw_head = 11'd3;
      k = 0;
      while (!xfer_req && k < 50) begin @(negedge clk); k++; end
      opt_run = 1'b0;
      repeat (40) @(negedge clk);
      chk(hw_tail == 2, "R9", "in-flight finished", 64'(hw_tail), 2);
      chk(n_xf - x0 == 1 && !xfer_req, "R9", "no next fetch", 64'(n_xf - x0), 1);
      opt_run = 1'b1;
      wait_tail(11'd3, 200, "R9");
      chk(n_xf - x0 == 2 && xf_addr_log[x0+1] == 64'hA2, "R9", "resume",
          xf_addr_log[x0+1], 64'hA2);
   endtask

   task automatic t_unposted;
      int r0, x0;
      opt_run = 1'b0;
      sw_head = 11'd0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      done_delay = 0;
      put_desc(0, 64'hBAD, ctlw(12'd9, 4'd0, 4'd0, 12'h008));
      r0 = n_rd; x0 = n_xf;
      sw_head = 11'd1;
      opt_run = 1'b1;
      repeat (30) @(negedge clk);
      chk(ring_err, "R8", "error raised", 64'(ring_err), 1);
      chk(hw_tail == 0 && n_xf == x0, "R8", "no transfer, tail kept", 64'(hw_tail), 0);
      chk(n_rd - r0 == 3, "R8", "reads stop", 64'(n_rd - r0), 3);
      repeat (20) @(negedge clk);
      chk(ring_err && n_rd - r0 == 3 && mem[18] == ctlw(12'd9, 4'd0, 4'd0, 12'h008),
          "R8", "sticky, no write", 64'(ring_err), 1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_idle();
      t_basic();
      t_wrap();
      t_run_drop();
      t_unposted();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      wait (cycles >= 20000);
      checks++;
      fails++;
      $display("FAIL watchdog: run hung actual=%0d expected=<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule